// File: doc/BRIEF.md
# Priority Interrupt Presenter

This block sits beside one hardware thread and decides whether that thread should be interrupted. Event sources deliver a one-cycle strobe carrying a 3-bit level. Each delivery sets one bit in an eight-bit pending bitmap. A bit's index is its level, and level 0 is the most urgent. From this bitmap the block derives the pending priority, which is the lowest set index. When no bit is set, the pending priority reads as 0xFF.

Software holds a current priority, which acts as a threshold. The exception flag and the CPU interrupt line are raised whenever the pending priority is numerically below the threshold. The check is repeated whenever either side changes.

Software changes the threshold with a write strobe. It takes an interrupt with an acknowledge read. The read returns the exception flag and the pending priority as they stand in that cycle. When the flag is set, the same clock edge does three things: it loads the pending priority into the threshold, clears that level's pending bit, and drops the flag.

Top module: `prio_presenter`

## Requirements
- R1: After reset, `pend_buf` is 0, `pend_prio` is 0xFF, `cur_prio` is 0xFF, and both `cpu_irq` and `exc_flag` are low.
- R2: A cycle with `dlv_valid` high and `dlv_prio` = p sets bit p of `pend_buf` (bit index equals level) at the next clock edge.
- R3: `pend_prio` equals the lowest index of a set bit in `pend_buf`, and reads 0xFF when `pend_buf` is 0.
- R4: `exc_flag` and `cpu_irq` are high exactly when `pend_prio` is not 0xFF and is strictly below the effective threshold. Threshold values 8 to 0xFF count as level 8, which is below every level's urgency.
- R5: A cycle with `cur_wr_en` high loads `cur_prio` with `cur_wr_data` at the next edge, with no masking. The interrupt output follows the new value in the cycle after that edge.
- R6: While `ack_rd` is high, `ack_data` bit 8 is the exception flag and bits 7:0 are `pend_prio`, both taken before that cycle's update.
- R7: An acknowledge with `exc_flag` high loads `cur_prio` with the pending priority and clears that level's pending bit at the next edge. The exception flag then falls unless a more urgent level is still pending.
- R8: An acknowledge with `exc_flag` low changes neither `pend_buf` nor `cur_prio`.
- R9: A delivery in the same cycle as a taken acknowledge is merged after the clear. The delivered bit is set afterwards even when it is the acknowledged level.
- R10: When a taken acknowledge and a threshold write fall in the same cycle, the acknowledge wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | One-cycle event delivery strobe |
| dlv_prio | input | 3 | Level of the delivered event |
| cur_wr_en | input | 1 | Threshold write strobe |
| cur_wr_data | input | 8 | Threshold value to write |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_data | output | 9 | {exception flag, pending priority} returned by the acknowledge |
| pend_buf | output | 8 | Pending bitmap, one bit per level |
| pend_prio | output | 8 | Most urgent pending level, 0xFF if none |
| cur_prio | output | 8 | Current threshold |
| exc_flag | output | 1 | Exception flag of the notification status |
| cpu_irq | output | 1 | Interrupt line to the thread |

## Verification
The checker watches the following properties on every cycle:
- a delivered level is pending one edge later;
- the pending priority always points at a set bit, or is 0xFF when none is set;
- an empty bitmap never raises the line, and a full-open threshold always raises it when something is pending;
- a taken acknowledge moves the pending level into the threshold;
- an untaken acknowledge leaves the state alone.

Some behaviours depend on exact values across a sequence, and only the bench's scenarios show them:
- the threshold values 8 to 0xFE compare the same as 0xFF;
- the data returned by the acknowledge is taken from before that cycle's update;
- a same-level delivery survives its own acknowledge;
- an acknowledge wins over a threshold write in the same cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_NONE = 8'hFF;

  // Effective threshold level: any value at or above the level count acts as
  // one step past the least urgent level.
  function automatic logic [PRIO_W:0] eff_level(prio_t v, int unsigned nlvl);
    if (32'(v) >= nlvl) return (PRIO_W+1)'(nlvl);
    return {1'b0, v};
  endfunction

  // Strict "more urgent" comparison between a pending level and a threshold.
  function automatic logic beats(logic any, prio_t lvl, prio_t cur,
                                 int unsigned nlvl);
    return any && ({1'b0, lvl} < eff_level(cur, nlvl));
  endfunction
endpackage

// File: rtl/pp_pend_buf.sv
module pp_pend_buf #(
  parameter int unsigned NUM_LVL = 8,
  localparam int unsigned LVL_W = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [LVL_W-1:0]   set_idx,
  input  logic               clr_en,
  input  logic [LVL_W-1:0]   clr_idx,
  output logic [NUM_LVL-1:0] bits_q
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == LVL_W'(g));
    assign hit_clr = clr_en && (clr_idx == LVL_W'(g));
    // set is merged after clear, so a fresh delivery is never lost
    always_ff @(posedge clk) begin
      if (!rst_n)       bits_q[g] <= 1'b0;
      else if (hit_set) bits_q[g] <= 1'b1;
      else if (hit_clr) bits_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_prio_enc.sv
module pp_prio_enc #(
  parameter int unsigned NUM_LVL = 8,
  localparam int unsigned LVL_W = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] vec,
  output logic               any,
  output logic [LVL_W-1:0]   idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (vec[i]) idx = LVL_W'(i);
    end
  end
endmodule

// File: rtl/pp_cur_reg.sv
module pp_cur_reg
  import pp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  prio_t wr_data,
  input  logic  ack_take,
  input  prio_t ack_val,
  output prio_t cur_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        cur_q <= PRIO_NONE;
    else if (ack_take) cur_q <= ack_val;
    else if (wr_en)    cur_q <= wr_data;
  end
endmodule

// File: rtl/pp_cmp.sv
module pp_cmp
  import pp_pkg::*;
#(
  parameter int unsigned NUM_LVL = 8
) (
  input  logic  pend_any,
  input  prio_t pend_lvl,
  input  prio_t cur,
  output logic  exc
);
  assign exc = beats(pend_any, pend_lvl, cur, NUM_LVL);
endmodule

// File: rtl/prio_presenter.sv
module prio_presenter
  import pp_pkg::*;
#(
  parameter int unsigned NUM_LVL = 8,
  localparam int unsigned LVL_W = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dlv_valid,
  input  logic [LVL_W-1:0]   dlv_prio,
  input  logic               cur_wr_en,
  input  logic [PRIO_W-1:0]  cur_wr_data,
  input  logic               ack_rd,
  output logic [PRIO_W:0]    ack_data,
  output logic [NUM_LVL-1:0] pend_buf,
  output logic [PRIO_W-1:0]  pend_prio,
  output logic [PRIO_W-1:0]  cur_prio,
  output logic               exc_flag,
  output logic               cpu_irq
);
  // named internal events
  logic             pend_any;
  logic [LVL_W-1:0] pend_idx;
  logic             ack_take;
  logic             exc_w;

  pp_pend_buf #(.NUM_LVL(NUM_LVL)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (dlv_valid),
    .set_idx(dlv_prio),
    .clr_en (ack_take),
    .clr_idx(pend_idx),
    .bits_q (pend_buf)
  );

  pp_prio_enc #(.NUM_LVL(NUM_LVL)) u_enc (
    .vec(pend_buf),
    .any(pend_any),
    .idx(pend_idx)
  );

  assign pend_prio = pend_any ? PRIO_W'(pend_idx) : PRIO_NONE;

  pp_cmp #(.NUM_LVL(NUM_LVL)) u_cmp (
    .pend_any(pend_any),
    .pend_lvl(pend_prio),
    .cur     (cur_prio),
    .exc     (exc_w)
  );

  assign ack_take = ack_rd && exc_w;

  pp_cur_reg u_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cur_wr_en),
    .wr_data (cur_wr_data),
    .ack_take(ack_take),
    .ack_val (pend_prio),
    .cur_q   (cur_prio)
  );

  assign exc_flag = exc_w;
  assign cpu_irq  = exc_w;
  assign ack_data = {exc_w, pend_prio};
endmodule

// File: rtl/pp_chk.sv
module pp_chk #(
  parameter int unsigned NUM_LVL = 8,
  localparam int unsigned LVL_W = $clog2(NUM_LVL)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dlv_valid,
  input logic [LVL_W-1:0]   dlv_prio,
  input logic               cur_wr_en,
  input logic               ack_rd,
  input logic [NUM_LVL-1:0] pend_buf,
  input logic [7:0]         pend_prio,
  input logic [7:0]         cur_prio,
  input logic               cpu_irq,
  input logic               exc_flag
);
  // R2
  dlv_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |=> pend_buf[$past(dlv_prio)]);

  // R3
  empty_reads_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_buf == '0) |-> (pend_prio == 8'hFF));

  // R3
  prio_points_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_buf != '0) |-> pend_buf[pend_prio[LVL_W-1:0]]);

  // R4
  no_irq_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_buf == '0) |-> !cpu_irq);

  // R4
  open_thresh_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_prio == 8'hFF && pend_buf != '0) |-> (cpu_irq && exc_flag));

  // R7
  ack_loads_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && exc_flag) |=> (cur_prio == $past(pend_prio)));

  // R8
  ack_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !exc_flag && !dlv_valid && !cur_wr_en)
      |=> ($stable(pend_buf) && $stable(cur_prio)));
endmodule

bind prio_presenter pp_chk #(.NUM_LVL(NUM_LVL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dlv_valid(dlv_valid),
  .dlv_prio (dlv_prio),
  .cur_wr_en(cur_wr_en),
  .ack_rd   (ack_rd),
  .pend_buf (pend_buf),
  .pend_prio(pend_prio),
  .cur_prio (cur_prio),
  .cpu_irq  (cpu_irq),
  .exc_flag (exc_flag)
);

// File: tb/sim_prio_presenter.sv
`timescale 1ns/1ps
module sim_prio_presenter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dlv_valid = 1'b0;
  logic [2:0] dlv_prio = '0;
  logic       cur_wr_en = 1'b0;
  logic [7:0] cur_wr_data = '0;
  logic       ack_rd = 1'b0;
  logic [8:0] ack_data;
  logic [7:0] pend_buf, pend_prio, cur_prio;
  logic       exc_flag, cpu_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_presenter u0 (.*);

  typedef struct {
    logic [7:0] buf_e;
    logic [7:0] pend_e;
    logic [7:0] cur_e;
    logic       irq_e;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] mbuf = 8'h00;
  logic [7:0] mcur = 8'hFF;

  function automatic logic [7:0] m_pend(logic [7:0] b);
    for (int i = 0; i < 8; i++) if (b[i]) return 8'(i);
    return 8'hFF;
  endfunction

  function automatic logic m_exc(logic [7:0] b, logic [7:0] c);
    int p, t;
    p = (b == 0) ? 999 : int'(m_pend(b));
    t = (c > 8'd7) ? 8 : int'(c);
    return p < t;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected state pushed to the scoreboard
  task automatic step(bit dv, logic [2:0] dp, bit we, logic [7:0] wd,
                      bit ak, string tag);
    logic [7:0] p;
    logic e;
    exp_t it;
    @(negedge clk);
    dlv_valid = dv; dlv_prio = dp;
    cur_wr_en = we; cur_wr_data = wd; ack_rd = ak;
    #1;
    p = m_pend(mbuf);
    e = m_exc(mbuf, mcur);
    if (ak) chk({tag, " R6 ack_data"}, 32'(ack_data), 32'({e, p}));
    if (ak && e) begin
      mcur = p;
      mbuf[p[2:0]] = 1'b0;
    end else if (we) begin
      mcur = wd;
    end
    if (dv) mbuf[dp] = 1'b1;
    it.buf_e = mbuf; it.pend_e = m_pend(mbuf);
    it.cur_e = mcur; it.irq_e = m_exc(mbuf, mcur); it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares the state after each edge with the popped expectation
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      chk({it.tag, " buf"},  32'(pend_buf),  32'(it.buf_e));
      chk({it.tag, " pend"}, 32'(pend_prio), 32'(it.pend_e));
      chk({it.tag, " cur"},  32'(cur_prio),  32'(it.cur_e));
      chk({it.tag, " irq"},  32'(cpu_irq),   32'(it.irq_e));
      chk({it.tag, " exc"},  32'(exc_flag),  32'(it.irq_e));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 buf",  32'(pend_buf),  32'h00);
    chk("R1 pend", 32'(pend_prio), 32'hFF);
    chk("R1 cur",  32'(cur_prio),  32'hFF);
    chk("R1 irq",  32'(cpu_irq),   32'h0);
    chk("R1 exc",  32'(exc_flag),  32'h0);

    step(1, 5, 0, 0, 0, "R2 deliver 5");
    step(1, 3, 0, 0, 0, "R3 deliver 3");
    step(1, 6, 0, 0, 0, "R3 deliver 6");
    step(0, 0, 1, 8'd3, 0, "R5 cur=3 masks 3");
    idle("R4 equal level no irq");
    step(0, 0, 1, 8'h10, 0, "R4 cur=0x10 acts as 8");
    step(0, 0, 1, 8'd8, 0, "R4 cur=8");
    step(0, 0, 0, 0, 1, "R7 take ack 3");
    step(0, 0, 0, 0, 1, "R8 ack no exc");
    step(0, 0, 1, 8'd0, 0, "R5 cur=0");
    step(0, 0, 0, 0, 1, "R8 ack with cur=0");
    step(0, 0, 1, 8'hFF, 0, "R5 cur=FF");
    step(1, 7, 0, 0, 1, "R9 deliver 7 with ack");
    step(0, 0, 1, 8'hFF, 0, "R5 reopen");
    step(1, 6, 0, 0, 1, "R9 same level deliver and ack");
    step(0, 0, 1, 8'hFF, 0, "R5 reopen again");
    step(0, 0, 1, 8'd0, 1, "R10 ack beats write");
    step(1, 1, 0, 0, 0, "R7 more urgent after ack");
    step(0, 0, 0, 0, 1, "R7 ack 1");
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 1, 8'hFF, 0, "R5 reopen drain");
      step(0, 0, 0, 0, 1, "R7 drain ack");
    end
    idle("R3 empty again");
    for (int lv = 7; lv >= 0; lv--) step(1, 3'(lv), 0, 0, 0, "R3 descending fill");
    step(0, 0, 1, 8'd2, 0, "R4 cur=2 keeps 0 and 1 above");
    idle("R4 settle");
    idle("R4 settle 2");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule